// File: doc/BRIEF.md
# Guest Load/Store Permission Gate

This block is a purely combinational filter that sits next to the address translation path. For each memory access it works out which privilege and virtualization mode the access really runs in. That mode can differ from the current one in two cases: machine mode has its modify-privilege control set, or the instruction is a hypervisor virtual-machine load/store. When the resulting mode is a guest mode, the block applies the guest's make-executable-readable and supervisor-user-access controls against the page's R, X and U bits.

Accesses whose effective mode is not a guest mode pass through untouched. The page-table walk, the second-stage permission check and the encoding of the fault cause all belong to neighbouring logic. This gate only produces the effective mode, a permit strobe and a fault strobe.

Privilege encoding on every privilege port: 0 = user, 1 = supervisor, 3 = machine. The value 2 is reserved and never driven.

Top module: `guest_access_gate`

## Requirements
- R1: When `acc_valid` is 0, `acc_permit` and `acc_fault` are both 0.
- R2: When `acc_valid` is 1, exactly one of `acc_permit` and `acc_fault` is 1.
- R3: The effective mode is derived as follows.
  - A hypervisor VM load/store (`hyp_vm_ls`=1) gives `eff_virt`=1 and `eff_priv`=1.
  - Otherwise, in machine mode with `m_prv_en`=1, `eff_priv` equals `m_prev_priv`, and `eff_virt` is `m_prev_virt` provided `m_prev_priv[1]`=0.
  - Otherwise `eff_priv` is `cur_priv`, and `eff_virt` is `cur_virt` whenever `cur_priv` is not machine.
- R4: In an effective guest mode, a load from a page with X=1 and R=0 is permitted when `gst_mxr`=1.
- R5: In an effective guest mode with `gst_mxr`=0, a load from an X=1, R=0 page is permitted only if `sup_mxr`=1. Otherwise it faults.
- R6: In an effective guest mode, a load from a page with R=0 and X=0 faults whatever the MXR bits hold.
- R7: In an effective guest mode, a store to a page with R=0 faults whatever the MXR bits hold.
- R8: In effective guest supervisor mode (`eff_virt`=1, `eff_priv`=1), any access to a page with U=1 faults when `gst_sum`=0 and is permitted when `gst_sum`=1, as long as the R/X rules allow it.
- R9: In effective guest user mode (`eff_virt`=1, `eff_priv`=0), the page's U bit and `gst_sum` do not change the outcome.
- R10: When `eff_virt`=0, every valid access is permitted regardless of page bits and MXR/SUM.
- R11: A hypervisor VM load/store is subject to guest MXR and guest SUM even when issued from non-virtualized supervisor or user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_valid | input | 1 | An access is being checked this cycle |
| acc_is_store | input | 1 | 1 = store, 0 = load |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt | input | 1 | Current virtualization mode |
| m_prv_en | input | 1 | Machine modify-privilege control |
| m_prev_virt | input | 1 | Machine previous virtualization mode |
| m_prev_priv | input | 2 | Machine previous privilege |
| sup_mxr | input | 1 | Supervisor-level make-executable-readable |
| gst_mxr | input | 1 | Guest make-executable-readable |
| gst_sum | input | 1 | Guest supervisor access to user pages |
| hyp_vm_ls | input | 1 | Access comes from a hypervisor VM load/store |
| pg_r | input | 1 | Page readable bit |
| pg_x | input | 1 | Page executable bit |
| pg_u | input | 1 | Page user bit |
| eff_virt | output | 1 | Effective virtualization mode |
| eff_priv | output | 2 | Effective privilege |
| acc_permit | output | 1 | Access allowed by this gate |
| acc_fault | output | 1 | Access denied by this gate |

## Verification
The block has no parameters, so the bench builds the single default form. It reaches each route into a guest mode: native VS and VU, machine mode redirected through the previous-mode fields, and hypervisor VM load/stores from S and U. In each of those it sweeps the page R/X/U bits against both MXR bits and SUM. It also covers the boundaries where redirection does not take effect, such as previous privilege machine, or modify-privilege set with previous virtualization 0.

// File: rtl/guest_access_gate.sv
module guest_access_gate (
  input  logic       acc_valid,
  input  logic       acc_is_store,
  input  logic [1:0] cur_priv,
  input  logic       cur_virt,
  input  logic       m_prv_en,
  input  logic       m_prev_virt,
  input  logic [1:0] m_prev_priv,
  input  logic       sup_mxr,
  input  logic       gst_mxr,
  input  logic       gst_sum,
  input  logic       hyp_vm_ls,
  input  logic       pg_r,
  input  logic       pg_x,
  input  logic       pg_u,
  output logic       eff_virt,
  output logic [1:0] eff_priv,
  output logic       acc_permit,
  output logic       acc_fault
);
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  logic in_m, redirect, readable, deny_rx, deny_sum, deny;

  assign in_m     = (cur_priv == PRIV_M);
  assign redirect = in_m && m_prv_en;

  always_comb begin
    if (hyp_vm_ls) begin
      eff_virt = 1'b1;
      eff_priv = PRIV_S;
    end else if (redirect) begin
      eff_virt = m_prev_virt && !m_prev_priv[1];
      eff_priv = m_prev_priv;
    end else begin
      eff_virt = cur_virt && !in_m;
      eff_priv = cur_priv;
    end
  end

  assign readable = pg_r || (pg_x && (gst_mxr || sup_mxr));
  assign deny_rx  = acc_is_store ? !pg_r : !readable;
  assign deny_sum = (eff_priv == PRIV_S) && pg_u && !gst_sum;
  assign deny     = eff_virt && (deny_rx || deny_sum);

  assign acc_permit = acc_valid && !deny;
  assign acc_fault  = acc_valid && deny;

  logic unused_u;
  assign unused_u = (PRIV_U != 2'd0);
endmodule

module guest_access_gate_chk (
  input logic       acc_valid,
  input logic       acc_is_store,
  input logic       hyp_vm_ls,
  input logic       gst_sum,
  input logic       pg_r,
  input logic       pg_u,
  input logic       eff_virt,
  input logic [1:0] eff_priv,
  input logic       acc_permit,
  input logic       acc_fault
);
  always_comb begin
    a_r1_idle_quiet: assert (acc_valid || (!acc_permit && !acc_fault))
      else $error("R1 strobe without access");
    a_r2_one_hot: assert (!acc_valid || $onehot({acc_permit, acc_fault}))
      else $error("R2 permit/fault not exclusive");
    a_r3_hyp_mode: assert (!hyp_vm_ls || (eff_virt && eff_priv == 2'd1))
      else $error("R3 hypervisor access not in guest S");
    a_r7_store_r0: assert (!(acc_valid && eff_virt && acc_is_store && !pg_r) || acc_fault)
      else $error("R7 store to R=0 not faulted");
    a_r8_sum_block: assert (!(acc_valid && eff_virt && eff_priv == 2'd1 && pg_u && !gst_sum) || acc_fault)
      else $error("R8 user page reached with SUM=0");
    a_r10_native: assert (!(acc_valid && !eff_virt) || acc_permit)
      else $error("R10 non-guest access denied");
  end
endmodule

bind guest_access_gate guest_access_gate_chk u_chk (
  .acc_valid(acc_valid), .acc_is_store(acc_is_store), .hyp_vm_ls(hyp_vm_ls),
  .gst_sum(gst_sum), .pg_r(pg_r), .pg_u(pg_u), .eff_virt(eff_virt),
  .eff_priv(eff_priv), .acc_permit(acc_permit), .acc_fault(acc_fault)
);

// File: tb/sim_guest_access_gate.sv
module sim_guest_access_gate;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       acc_valid, acc_is_store, cur_virt, m_prv_en, m_prev_virt;
  logic [1:0] cur_priv, m_prev_priv, eff_priv;
  logic       sup_mxr, gst_mxr, gst_sum, hyp_vm_ls, pg_r, pg_x, pg_u;
  logic       eff_virt, acc_permit, acc_fault;
  int total = 0, bad = 0;

  guest_access_gate u0 (.*);

  task automatic clear();
    @(negedge clk);
    acc_valid = 1; acc_is_store = 0; cur_priv = 2'd1; cur_virt = 0;
    m_prv_en = 0; m_prev_virt = 0; m_prev_priv = 2'd0;
    sup_mxr = 0; gst_mxr = 0; gst_sum = 0; hyp_vm_ls = 0;
    pg_r = 1; pg_x = 0; pg_u = 0;
  endtask

  task automatic expect_acc(string tag, logic exp_ok);
    #2;
    total++;
    if (acc_permit !== exp_ok || acc_fault !== !exp_ok) begin
      bad++;
      $display("FAIL %s: permit/fault=%b%b expected %b%b", tag, acc_permit, acc_fault, exp_ok, !exp_ok);
    end
  endtask

  task automatic expect_mode(string tag, logic ev, logic [1:0] ep);
    #2;
    total++;
    if (eff_virt !== ev || eff_priv !== ep) begin
      bad++;
      $display("FAIL %s: mode=%b/%0d expected %b/%0d", tag, eff_virt, eff_priv, ev, ep);
    end
  endtask

  task automatic t_idle();
    clear(); acc_valid = 0; pg_r = 0; cur_virt = 1;
    #2; total++;
    if (acc_permit !== 0 || acc_fault !== 0) begin
      bad++; $display("FAIL R1: permit/fault=%b%b expected 00", acc_permit, acc_fault);
    end
  endtask

  task automatic t_modes();
    clear(); cur_virt = 1; cur_priv = 2'd0; expect_mode("R3 native VU", 1, 2'd0);
    clear(); cur_virt = 1; cur_priv = 2'd3; expect_mode("R3 M ignores virt", 0, 2'd3);
    clear(); cur_priv = 2'd3; m_prv_en = 1; m_prev_virt = 1; m_prev_priv = 2'd1;
    expect_mode("R3 M redirect VS", 1, 2'd1);
    clear(); cur_priv = 2'd3; m_prv_en = 1; m_prev_virt = 1; m_prev_priv = 2'd3;
    expect_mode("R3 M redirect to M", 0, 2'd3);
    clear(); cur_priv = 2'd3; m_prv_en = 1; m_prev_virt = 0; m_prev_priv = 2'd0;
    expect_mode("R3 M redirect host U", 0, 2'd0);
    clear(); cur_priv = 2'd0; hyp_vm_ls = 1; expect_mode("R3 hyp from U", 1, 2'd1);
  endtask

  task automatic t_mxr();
    clear(); cur_virt = 1; pg_r = 0; pg_x = 1; gst_mxr = 1; expect_acc("R4 VS gst_mxr", 1);
    clear(); cur_virt = 1; cur_priv = 2'd0; pg_r = 0; pg_x = 1; gst_mxr = 1; expect_acc("R4 VU gst_mxr", 1);
    clear(); cur_virt = 1; pg_r = 0; pg_x = 1; sup_mxr = 1; expect_acc("R5 sup_mxr", 1);
    clear(); cur_virt = 1; pg_r = 0; pg_x = 1; expect_acc("R5 no mxr", 0);
    clear(); cur_priv = 2'd3; m_prv_en = 1; m_prev_virt = 1; m_prev_priv = 2'd0;
    pg_r = 0; pg_x = 1; expect_acc("R5 M redirect VU no mxr", 0);
    clear(); cur_virt = 1; pg_r = 0; pg_x = 0; gst_mxr = 1; sup_mxr = 1; expect_acc("R6 no R no X", 0);
  endtask

  task automatic t_store();
    clear(); cur_virt = 1; acc_is_store = 1; pg_r = 0; pg_x = 1; gst_mxr = 1; sup_mxr = 1;
    expect_acc("R7 store R0", 0);
    clear(); cur_virt = 1; acc_is_store = 1; expect_acc("R7 store R1", 1);
  endtask

  task automatic t_sum();
    clear(); cur_virt = 1; pg_u = 1; expect_acc("R8 VS U sum0", 0);
    clear(); cur_virt = 1; pg_u = 1; gst_sum = 1; acc_is_store = 1; expect_acc("R8 VS U sum1 store", 1);
    clear(); cur_priv = 2'd3; m_prv_en = 1; m_prev_virt = 1; m_prev_priv = 2'd1; pg_u = 1;
    expect_acc("R8 M redirect VS sum0", 0);
    clear(); cur_virt = 1; cur_priv = 2'd0; pg_u = 1; expect_acc("R9 VU U page", 1);
    clear(); cur_virt = 1; cur_priv = 2'd0; pg_u = 0; gst_sum = 1; expect_acc("R9 VU S page", 1);
  endtask

  task automatic t_native();
    clear(); pg_r = 0; pg_u = 1; expect_acc("R10 host S", 1);
    clear(); cur_priv = 2'd3; pg_r = 0; acc_is_store = 1; expect_acc("R10 M", 1);
    clear(); cur_priv = 2'd3; m_prv_en = 1; m_prev_virt = 0; m_prev_priv = 2'd1; pg_r = 0; pg_u = 1;
    expect_acc("R10 M redirect host", 1);
  endtask

  task automatic t_hyp();
    clear(); hyp_vm_ls = 1; pg_u = 1; expect_acc("R11 hyp sum0", 0);
    clear(); hyp_vm_ls = 1; cur_priv = 2'd0; pg_r = 0; pg_x = 1; gst_mxr = 1; expect_acc("R11 hyp mxr", 1);
    clear(); hyp_vm_ls = 1; pg_r = 0; pg_x = 1; expect_acc("R11 hyp no mxr", 0);
    clear(); cur_virt = 1; acc_is_store = 1; pg_r = 0; #2; total++;
    if (!$onehot({acc_permit, acc_fault})) begin
      bad++; $display("FAIL R2: permit/fault=%b%b expected one-hot", acc_permit, acc_fault);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_idle();
    t_modes();
    t_mxr();
    t_store();
    t_sum();
    t_native();
    t_hyp();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule